// File: doc/BRIEF.md
# Sensorless Motor Start-Up and Fault Sequencer

This block steps a three-phase brushless drive from power-up to closed-loop running without a position sensor. After reset it passes through a short initialisation step and a timed current-offset calibration window. It then holds the rotor on a fixed alignment vector at a set duty. Next it commutates open-loop, with each commutation interval shorter than the one before, and finally it hands control to the closed-loop speed path. When the operator stops the drive, a freewheel wait runs out before the drive may align again.

Four fault flags are merged into one condition: bus undervoltage, bus overvoltage, bus overcurrent and gate-driver fault. This condition takes the drive to a latched safe state with every output off. The drive leaves that state only when all flags have cleared and an explicit clear request is present.

The block drives no switches. It tells the PWM stage which pattern to apply (off, alignment vector, or the commutation sector), the duty to use during alignment, and the commutation interval during the open-loop ramp. It also tells the closed-loop controller when to take over. Time is counted in pulses of a millisecond tick, and the PWM stage reports each completed commutation with a one-cycle strobe.

Top module: `motor_start_seq`

## Requirements
- R1: While reset is high, and on the first edge of each visit to INIT, the state code is 0, the pattern is off (0), and the alignment duty, open-loop period and closed-loop enable are 0. From INIT the next state is CALIB (1) when the run switch is 1, and STOP (5) otherwise.
- R2: CALIB (code 1) keeps the pattern off for CALIB_MS millisecond ticks counted from entry, then moves to ALIGNMENT (2).
- R3: ALIGNMENT (code 2) selects the alignment pattern (1) with duty ALIGN_DUTY for ALIGN_MS ticks from entry, then moves to START (3).
- R4: START (code 3) selects the sector pattern (2). The open-loop period starts at INIT_PERIOD. Each commutation strobe replaces it with floor(period × ACCEL / 65536), where ACCEL is an unsigned 16-bit fraction. After START_COMMS strobes the state becomes RUN (4).
- R5: RUN (code 4) selects the sector pattern, sets the closed-loop enable to 1 and drives the open-loop period to 0. A run switch of 0 in CALIB, ALIGNMENT, START or RUN returns the drive to INIT.
- R6: On entry to STOP (code 5) the freewheel counter is loaded with FREEWHEEL_MS, and it drops by one on each tick. STOP keeps every output off and moves to ALIGNMENT only when the run switch is 1 and the counter is 0.
- R7: Any set bit of the fault vector sends the drive to FAULT (code 6) on the next edge, from every state. This overrides every other transition in that cycle. In FAULT all outputs are 0 and the pattern is off. The fault vector bits are: bit 0 undervoltage, bit 1 overvoltage, bit 2 overcurrent, bit 3 gate-driver fault.
- R8: FAULT stays latched until a cycle in which the fault vector is all zero and the clear request is 1. On that cycle it moves to INIT.
- R9: The open-loop period never falls below MIN_PERIOD. A shrunk value below the floor is replaced by MIN_PERIOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_sw | input | 1 | Operator run switch |
| fault_clr | input | 1 | Request to release the fault latch |
| fault_flags | input | 4 | Undervoltage, overvoltage, overcurrent, gate-driver fault (bits 0..3) |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| comm_done | input | 1 | One-cycle strobe per completed commutation |
| state_code | output | 3 | Current sequencer state |
| pattern_sel | output | 2 | 0 off, 1 alignment vector, 2 commutation sector |
| align_duty | output | DUTY_W | Duty applied during alignment, else 0 |
| ol_period | output | PER_W | Open-loop commutation period in START, else 0 |
| cl_enable | output | 1 | Closed-loop control enable |

## Verification
All outputs are registered together with the state. A change on run_sw, fault_flags, fault_clr or comm_done is visible on the outputs after exactly one rising edge. A timed state ends on the edge after the tick that takes its counter to zero, so a window lasts N ticks plus at most one cycle. The bench drives inputs at the falling edge and compares the outputs with its model at the next falling edge. Every comparison therefore lands one edge after the stimulus, and the directed checks follow the same one-edge rule.

// File: rtl/mss_pkg.sv
package mss_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_CALIB = 3'd1,
    ST_ALIGN = 3'd2,
    ST_START = 3'd3,
    ST_RUN   = 3'd4,
    ST_STOP  = 3'd5,
    ST_FAULT = 3'd6
  } mss_state_e;

  typedef enum logic [1:0] {
    PAT_OFF    = 2'd0,
    PAT_ALIGN  = 2'd1,
    PAT_SECTOR = 2'd2
  } mss_pat_e;

  localparam int FLT_W = 4;

endpackage

// File: rtl/mss_fault_merge.sv
module mss_fault_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0] flags,
  output logic         any_fault
);

  logic [N:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_or
    assign chain[i+1] = chain[i] | flags[i];
  end

  assign any_fault = chain[N];

endmodule

// File: rtl/mss_ms_timer.sv
module mss_ms_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/mss_ol_ramp.sv
module mss_ol_ramp #(
  parameter int PER_W       = 16,
  parameter int INIT_PERIOD = 1000,
  parameter int MIN_PERIOD  = 400,
  parameter int ACCEL       = 57344,
  parameter int COMMS       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             clear,
  output logic [PER_W-1:0] period,
  output logic             last
);

  localparam int CNT_W  = (COMMS < 2) ? 1 : $clog2(COMMS);
  localparam int PROD_W = PER_W + 16;
  localparam logic [15:0]      ACC16  = ACCEL[15:0];
  localparam logic [PER_W-1:0] INIT_V = PER_W'(INIT_PERIOD);
  localparam logic [PER_W-1:0] MIN_V  = PER_W'(MIN_PERIOD);

  logic [PER_W-1:0]  per_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PROD_W-1:0] prod;
  logic [PER_W-1:0]  shrunk;
  logic [PER_W-1:0]  floored;

  assign prod    = PROD_W'(per_q) * PROD_W'(ACC16);
  assign shrunk  = prod[PROD_W-1:16];
  assign floored = (shrunk < MIN_V) ? MIN_V : shrunk;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      per_q <= INIT_V;
      cnt_q <= '0;
    end else if (step) begin
      per_q <= floored;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign period = per_q;
  assign last   = (32'(cnt_q) == COMMS - 1);

endmodule

// File: rtl/motor_start_seq.sv
module motor_start_seq
  import mss_pkg::*;
#(
  parameter int DUTY_W       = 10,
  parameter int ALIGN_DUTY   = 300,
  parameter int PER_W        = 16,
  parameter int INIT_PERIOD  = 1000,
  parameter int MIN_PERIOD   = 400,
  parameter int ACCEL        = 57344,
  parameter int START_COMMS  = 8,
  parameter int CALIB_MS     = 2,
  parameter int ALIGN_MS     = 4,
  parameter int FREEWHEEL_MS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_sw,
  input  logic              fault_clr,
  input  logic [3:0]        fault_flags,
  input  logic              ms_tick,
  input  logic              comm_done,
  output logic [2:0]        state_code,
  output logic [1:0]        pattern_sel,
  output logic [DUTY_W-1:0] align_duty,
  output logic [PER_W-1:0]  ol_period,
  output logic              cl_enable
);

  localparam int MAX_AB = (CALIB_MS > ALIGN_MS) ? CALIB_MS : ALIGN_MS;
  localparam int MAX_MS = (MAX_AB > FREEWHEEL_MS) ? MAX_AB : FREEWHEEL_MS;
  localparam int TIM_W  = (MAX_MS < 2) ? 1 : $clog2(MAX_MS + 1);
  localparam logic [DUTY_W-1:0] ADUTY = DUTY_W'(ALIGN_DUTY);

  mss_state_e        state_q, state_d;
  logic              fault_any;
  logic              tim_load, tim_zero;
  logic [TIM_W-1:0]  tim_val;
  logic              ramp_load, ramp_step, ramp_clear, ramp_last;
  mss_pat_e          pat_q, pat_d;
  logic [DUTY_W-1:0] duty_q;
  logic              clen_q;

  mss_fault_merge #(.N(FLT_W)) u_fault (
    .flags     (fault_flags),
    .any_fault (fault_any)
  );

  // next-state selection; a fault overrides every other branch
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:  state_d = run_sw ? ST_CALIB : ST_STOP;
      ST_CALIB: if (!run_sw) state_d = ST_INIT;
                else if (tim_zero) state_d = ST_ALIGN;
      ST_ALIGN: if (!run_sw) state_d = ST_INIT;
                else if (tim_zero) state_d = ST_START;
      ST_START: if (!run_sw) state_d = ST_INIT;
                else if (comm_done && ramp_last) state_d = ST_RUN;
      ST_RUN:   if (!run_sw) state_d = ST_INIT;
      ST_STOP:  if (run_sw && tim_zero) state_d = ST_ALIGN;
      ST_FAULT: if (!fault_any && fault_clr) state_d = ST_INIT;
      default:  state_d = ST_INIT;
    endcase
    if (fault_any) state_d = ST_FAULT;
  end

  // one shared millisecond timer, loaded on entry to a timed state
  always_comb begin
    tim_load = 1'b0;
    tim_val  = '0;
    if (state_d != state_q) begin
      unique case (state_d)
        ST_CALIB: begin tim_load = 1'b1; tim_val = TIM_W'(CALIB_MS);     end
        ST_ALIGN: begin tim_load = 1'b1; tim_val = TIM_W'(ALIGN_MS);     end
        ST_STOP:  begin tim_load = 1'b1; tim_val = TIM_W'(FREEWHEEL_MS); end
        default:  begin tim_load = 1'b0; tim_val = '0;                   end
      endcase
    end
  end

  mss_ms_timer #(.W(TIM_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tim_load),
    .load_val (tim_val),
    .tick     (ms_tick),
    .expired  (tim_zero)
  );

  assign ramp_clear = (state_d != ST_START);
  assign ramp_load  = (state_d == ST_START) && (state_q != ST_START);
  assign ramp_step  = (state_q == ST_START) && comm_done;

  mss_ol_ramp #(
    .PER_W       (PER_W),
    .INIT_PERIOD (INIT_PERIOD),
    .MIN_PERIOD  (MIN_PERIOD),
    .ACCEL       (ACCEL),
    .COMMS       (START_COMMS)
  ) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .load   (ramp_load),
    .step   (ramp_step),
    .clear  (ramp_clear),
    .period (ol_period),
    .last   (ramp_last)
  );

  always_comb begin
    unique case (state_d)
      ST_ALIGN:        pat_d = PAT_ALIGN;
      ST_START, ST_RUN: pat_d = PAT_SECTOR;
      default:         pat_d = PAT_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
      pat_q   <= PAT_OFF;
      duty_q  <= '0;
      clen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pat_q   <= pat_d;
      duty_q  <= (state_d == ST_ALIGN) ? ADUTY : '0;
      clen_q  <= (state_d == ST_RUN);
    end
  end

  assign state_code  = state_q;
  assign pattern_sel = pat_q;
  assign align_duty  = duty_q;
  assign cl_enable   = clen_q;

endmodule

// File: rtl/mss_checker.sv
module mss_checker #(
  parameter int DUTY_W     = 10,
  parameter int PER_W      = 16,
  parameter int ALIGN_DUTY = 300,
  parameter int MIN_PERIOD = 400
) (
  input logic              clk,
  input logic              rst,
  input logic              run_sw,
  input logic              fault_clr,
  input logic [3:0]        fault_flags,
  input logic [2:0]        state_code,
  input logic [1:0]        pattern_sel,
  input logic [DUTY_W-1:0] align_duty,
  input logic [PER_W-1:0]  ol_period,
  input logic              cl_enable
);

  assert_init_branch_R1: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd0 && fault_flags == 4'd0) |=> (state_code == 3'd1 || state_code == 3'd5));

  assert_align_out_R3: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd2 |-> (pattern_sel == 2'd1 && align_duty == DUTY_W'(ALIGN_DUTY)));

  assert_ramp_shrink_R4: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd3 && $past(state_code) == 3'd3) |-> ol_period <= $past(ol_period));

  assert_period_floor_R9: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd3 |-> ol_period >= PER_W'(MIN_PERIOD));

  assert_run_outputs_R5: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd4 |-> (cl_enable && pattern_sel == 2'd2 && ol_period == '0));

  assert_run_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd4 && !run_sw && fault_flags == 4'd0) |=> state_code == 3'd0);

  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd5 && !run_sw && fault_flags == 4'd0) |=> state_code == 3'd5);

  assert_fault_entry_R7: assert property (@(posedge clk) disable iff (rst)
    fault_flags != 4'd0 |=> state_code == 3'd6);

  assert_fault_safe_R7: assert property (@(posedge clk) disable iff (rst)
    state_code == 3'd6 |-> (pattern_sel == 2'd0 && align_duty == '0 && ol_period == '0 && !cl_enable));

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd6 && !(fault_flags == 4'd0 && fault_clr)) |=> state_code == 3'd6);

  assert_fault_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd6 && fault_flags == 4'd0 && fault_clr) |=> state_code == 3'd0);

endmodule

bind motor_start_seq mss_checker #(
  .DUTY_W     (DUTY_W),
  .PER_W      (PER_W),
  .ALIGN_DUTY (ALIGN_DUTY),
  .MIN_PERIOD (MIN_PERIOD)
) i_mss_checker (
  .clk         (clk),
  .rst         (rst),
  .run_sw      (run_sw),
  .fault_clr   (fault_clr),
  .fault_flags (fault_flags),
  .state_code  (state_code),
  .pattern_sel (pattern_sel),
  .align_duty  (align_duty),
  .ol_period   (ol_period),
  .cl_enable   (cl_enable)
);

// File: tb/test_motor_start_seq.sv
module test_motor_start_seq;

  localparam int DUTY_W       = 10;
  localparam int ALIGN_DUTY   = 300;
  localparam int PER_W        = 16;
  localparam int INIT_PERIOD  = 1000;
  localparam int MIN_PERIOD   = 400;
  localparam int ACCEL        = 57344;
  localparam int START_COMMS  = 8;
  localparam int CALIB_MS     = 2;
  localparam int ALIGN_MS     = 4;
  localparam int FREEWHEEL_MS = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              run_sw = 1'b0;
  logic              fault_clr = 1'b0;
  logic [3:0]        fault_flags = 4'd0;
  logic              ms_tick = 1'b0;
  logic              comm_done = 1'b0;
  logic [2:0]        state_code;
  logic [1:0]        pattern_sel;
  logic [DUTY_W-1:0] align_duty;
  logic [PER_W-1:0]  ol_period;
  logic              cl_enable;

  always #5 clk = ~clk;

  motor_start_seq #(
    .DUTY_W(DUTY_W), .ALIGN_DUTY(ALIGN_DUTY), .PER_W(PER_W),
    .INIT_PERIOD(INIT_PERIOD), .MIN_PERIOD(MIN_PERIOD), .ACCEL(ACCEL),
    .START_COMMS(START_COMMS), .CALIB_MS(CALIB_MS), .ALIGN_MS(ALIGN_MS),
    .FREEWHEEL_MS(FREEWHEEL_MS)
  ) i_motor_start_seq (
    .clk(clk), .rst(rst), .run_sw(run_sw), .fault_clr(fault_clr),
    .fault_flags(fault_flags), .ms_tick(ms_tick), .comm_done(comm_done),
    .state_code(state_code), .pattern_sel(pattern_sel), .align_duty(align_duty),
    .ol_period(ol_period), .cl_enable(cl_enable)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int wd = 0;
  bit done = 1'b0;

  // behavioural model: state number, ms counter, period, strobes seen
  int m_state = 0;
  int m_tim = 0;
  int m_per = 0;
  int m_cnt = 0;

  always @(posedge clk) begin : model
    int nx;
    int np;
    int nc;
    int nt;
    if (rst) begin
      m_state <= 0; m_tim <= 0; m_per <= 0; m_cnt <= 0;
    end else begin
      nx = m_state;
      case (m_state)
        0: nx = run_sw ? 1 : 5;
        1: if (!run_sw) nx = 0; else if (m_tim == 0) nx = 2;
        2: if (!run_sw) nx = 0; else if (m_tim == 0) nx = 3;
        3: if (!run_sw) nx = 0; else if (comm_done && m_cnt + 1 == START_COMMS) nx = 4;
        4: if (!run_sw) nx = 0;
        5: if (run_sw && m_tim == 0) nx = 2;
        6: if (fault_flags == 0 && fault_clr) nx = 0;
        default: nx = 0;
      endcase
      if (fault_flags != 0) nx = 6;
      nt = m_tim;
      if (nx != m_state && nx == 1) nt = CALIB_MS;
      else if (nx != m_state && nx == 2) nt = ALIGN_MS;
      else if (nx != m_state && nx == 5) nt = FREEWHEEL_MS;
      else if (ms_tick && m_tim > 0) nt = m_tim - 1;
      np = m_per; nc = m_cnt;
      if (nx != 3) begin np = 0; nc = 0; end
      else if (m_state != 3) begin np = INIT_PERIOD; nc = 0; end
      else if (comm_done) begin
        np = (m_per * ACCEL) / 65536;
        if (np < MIN_PERIOD) np = MIN_PERIOD;
        nc = m_cnt + 1;
      end
      m_state <= nx; m_tim <= nt; m_per <= np; m_cnt <= nc;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic cmp_all();
    int ep;
    string t;
    t  = tag_of(m_state);
    ep = (m_state == 2) ? 1 : ((m_state == 3 || m_state == 4) ? 2 : 0);
    check(t, "state", int'(state_code), m_state);
    check(t, "pattern", int'(pattern_sel), ep);
    check(t, "duty", int'(align_duty), (m_state == 2) ? ALIGN_DUTY : 0);
    check(t, "period", int'(ol_period), m_per);
    check(t, "cl_enable", int'(cl_enable), (m_state == 4) ? 1 : 0);
    if (m_state == 3) check("R9", "period at or above floor", int'(ol_period >= MIN_PERIOD), 1);
  endtask

  task automatic step();
    @(negedge clk);
    cmp_all();
    ms_tick   = (cyc % 5 == 4);
    comm_done = (cyc % 7 == 3);
    cyc++;
  endtask

  task automatic expect_state(string tag, int exp);
    check(tag, "state (directed)", int'(state_code), exp);
  endtask

  task automatic wait_state(string tag, int s, int lim);
    int n = 0;
    while (m_state != s && n < lim) begin step(); n++; end
    check(tag, "reached state", m_state, s);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, got %0d expected 0", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    expect_state("R1", 0);
    check("R1", "pattern in reset", int'(pattern_sel), 0);
    rst = 1'b0;
    step();
    expect_state("R1", 5);
    repeat (40) step();
    expect_state("R6", 5);

    run_sw = 1'b1;
    wait_state("R3", 2, 200);
    wait_state("R4", 3, 200);
    check("R4", "initial period", int'(ol_period), INIT_PERIOD);
    wait_state("R4", 4, 500);
    repeat (10) step();
    check("R5", "closed-loop enable", int'(cl_enable), 1);

    run_sw = 1'b0;
    step();
    expect_state("R5", 0);
    step();
    expect_state("R1", 5);
    run_sw = 1'b1;
    step();
    expect_state("R6", 5);
    wait_state("R6", 2, 200);
    wait_state("R5", 4, 800);

    fault_flags = 4'b0100;
    step();
    expect_state("R7", 6);
    check("R7", "pattern off in fault", int'(pattern_sel), 0);
    fault_clr = 1'b1;
    repeat (3) step();
    expect_state("R8", 6);
    fault_flags = 4'd0;
    fault_clr = 1'b0;
    repeat (3) step();
    expect_state("R8", 6);
    fault_clr = 1'b1;
    step();
    expect_state("R8", 0);
    fault_clr = 1'b0;
    step();
    expect_state("R2", 1);

    for (int b = 0; b < 4; b++) begin
      wait_state("R4", 3, 800);
      fault_flags = 4'(1 << b);
      step();
      expect_state("R7", 6);
      fault_flags = 4'd0;
      fault_clr = 1'b1;
      step();
      fault_clr = 1'b0;
    end

    wait_state("R5", 4, 1500);
    run_sw = 1'b0;
    fault_flags = 4'b0001;
    step();
    expect_state("R7", 6);
    fault_flags = 4'd0;
    fault_clr = 1'b1;
    step();
    fault_clr = 1'b0;
    repeat (5) step();
    expect_state("R6", 5);
    fault_flags = 4'b1000;
    step();
    expect_state("R7", 6);
    fault_flags = 4'd0;
    fault_clr = 1'b1;
    step();
    fault_clr = 1'b0;

    run_sw = 1'b1;
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    expect_state("R2", 1);
    wait_state("R3", 2, 200);
    run_sw = 1'b0;
    step();
    expect_state("R5", 0);
    repeat (5) step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule